// File: doc/BRIEF.md
# Eight-Bit Compare Timer

This block is an 8-bit up-counter driven by an internal divided clock enable. It holds two compare registers, of which register A triggers events. When the counter equals compare A on an enabled tick, the block raises a compare flag and applies a programmable action to a single output pin. It can optionally restart the count from zero. When the counter wraps past its top value, the block raises an overflow flag. Each flag drives an interrupt line through its own enable bit. A host reaches every setting through a byte-wide register bus with a combinational read path.

Two one-shot strobes act on the block directly. The first forces the compare-A pin action without a real match. The second restarts the clock divider. A write to the counter blocks the compare match on the timer tick that follows. This lets software load the counter with the compare value without triggering a spurious event. A small state machine inside the counter tracks this. It has two states: `BLK_OPEN`, where matches are live, and `BLK_ARMED`, where the next tick is blind to a match. A counter write moves it from `BLK_OPEN` to `BLK_ARMED`, or keeps it in `BLK_ARMED`. An enabled tick with no counter write returns it from `BLK_ARMED` to `BLK_OPEN`. Reset places it in `BLK_OPEN`.

Register map, by bus address:
- 0 is control. Bits [3:0] select the clock, bits [5:4] set the output mode, bit 6 enables PWM and bit 7 enables clear-on-compare.
- 1 is the counter.
- 2 is compare A.
- 3 is compare B.
- 4 holds the interrupt enables. Bit 0 enables overflow and bit 1 enables compare.
- 5 holds the flags. Bit 0 is overflow and bit 1 is compare A.
- 6 holds the strobes. Bit 0 forces a compare and bit 1 resets the prescaler.
- 7 reads as zero.

Top module: `timer8_top`

## Requirements
- R1: After reset every register reads 0x00, the pin is low and both interrupt lines are low.
- R2: Clock select code 0 stops the counter. Code n from 1 to 15 advances it by one every 2^(n-1) clock cycles.
- R3: Writing 1 to strobe bit 1 restarts the divider, so that the next tick under code n falls 2^(n-1) cycles after the write edge. The strobe register always reads 0x00.
- R4: An enabled tick on which the counter equals compare A sets the compare flag (flag bit 1) and applies the pin action.
- R5: With control bit 7 set, a match loads 0x00 in place of the increment. With bit 7 clear, the counter keeps counting through the match.
- R6: Output mode 00 leaves the pin unchanged, 01 toggles it, 10 drives it low and 11 drives it high.
- R7: A counter write takes priority over a tick on the same cycle. The first tick after the write can never produce a match.
- R8: An increment from 0xFF to 0x00 sets the overflow flag (flag bit 0). A clear-on-compare from 0xFF does not.
- R9: Writing 1 to a flag bit clears it, and writing 0 has no effect. A pulse on the matching acknowledge input also clears it. A new event in the same cycle wins.
- R10: Each interrupt line is high exactly while its flag and its enable bit are both set.
- R11: Writing 1 to strobe bit 0 applies the configured pin action. It sets no flag and leaves the counter unchanged, even with clear-on-compare set.
- R12: With control bit 6 set, the force strobe leaves the pin unchanged.
- R13: Compare B reads back what was written and does not affect the counter, the flags or the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ack_ovf | input | 1 | Clears the overflow flag |
| ack_cmp | input | 1 | Clears the compare flag |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_cmp | output | 1 | Compare-A interrupt |
| cmp_pin | output | 1 | Compare-A output pin |

## Verification
On every cycle, the assertions check several local rules:
- the counter holds without a tick or write;
- a clear-on-compare match lands on zero;
- an overflow lands on zero;
- an armed tick only increments;
- the divider stays quiet right after a restart;
- a flag rises only from its event;
- the forced pin stays still in PWM mode;
- the strobe register reads zero.

Only the directed scenarios show the rest:
- the exact divide ratio;
- the cycle-accurate match position;
- each pin mode;
- the flag clearing paths and interrupt gating;
- the lack of an overflow on a clear from 0xFF;
- compare B having no effect.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

    localparam int CNT_W  = 8;
    localparam int CSEL_W = 4;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_COUNT  = 3'd1,
        A_CMPA   = 3'd2,
        A_CMPB   = 3'd3,
        A_IE     = 3'd4,
        A_FLAGS  = 3'd5,
        A_STROBE = 3'd6,
        A_SPARE  = 3'd7
    } reg_addr_t;

    typedef enum logic [1:0] {
        OM_NONE   = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_LOW    = 2'b10,
        OM_HIGH   = 2'b11
    } out_mode_t;

    typedef enum logic {
        BLK_OPEN  = 1'b0,
        BLK_ARMED = 1'b1
    } blk_state_t;

    // control register bit positions
    localparam int CTL_MODE_LO = 4;
    localparam int CTL_PWM     = 6;
    localparam int CTL_CLR     = 7;

    // flag / enable / strobe bit positions
    localparam int FB_OVF   = 0;
    localparam int FB_CMP   = 1;
    localparam int SB_FORCE = 0;
    localparam int SB_PRST  = 1;

endpackage

// File: rtl/timer8_prescale.sv
module timer8_prescale
    import timer8_pkg::*;
#(
    parameter int SEL_W = CSEL_W,
    parameter int DIV_W = (2 ** SEL_W) - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] csel,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= '0;
        else if (restart) div_q <= '0;
        else              div_q <= div_q + 1'b1;
    end

    always_comb begin
        mask = '0;
        for (int i = 0; i < DIV_W; i++) begin
            if (i < int'(csel) - 1) mask[i] = 1'b1;
        end
    end

    assign tick = (csel != '0) && ((div_q & mask) == mask);

    // R3: directly after a restart no tick is possible for codes above 1
    a_r3_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!tick || csel <= 1));

endmodule

// File: rtl/timer8_count.sv
module timer8_count
    import timer8_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cmpa,
    input  logic         clr_on_match,
    output logic [W-1:0] count,
    output logic         match,
    output logic         ovf
);

    localparam logic [W-1:0] TOP = '1;

    blk_state_t   blk_q, blk_d;
    logic [W-1:0] count_d;
    logic         eff_tick;
    logic         clear_now;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) blk_q <= BLK_OPEN;
        else        blk_q <= blk_d;
    end

    always_comb begin
        blk_d = blk_q;
        unique case (blk_q)
            BLK_OPEN:  if (wr_en) blk_d = BLK_ARMED;
            BLK_ARMED: if (!wr_en && tick) blk_d = BLK_OPEN;
        endcase
    end

    // outputs and datapath
    always_comb begin
        eff_tick  = tick && !wr_en;
        match     = 1'b0;
        unique case (blk_q)
            BLK_OPEN:  match = eff_tick && (count == cmpa);
            BLK_ARMED: match = 1'b0;
        endcase
        clear_now = match && clr_on_match;
        ovf       = eff_tick && !clear_now && (count == TOP);
        if (wr_en)          count_d = wr_data;
        else if (clear_now) count_d = '0;
        else if (eff_tick)  count_d = count + 1'b1;
        else                count_d = count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count_d;
    end

    // R2: without a tick or write the counter holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(count));
    // R5: clear-on-compare lands on zero
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (match && clr_on_match) |=> (count == '0));
    // R7: the tick after a write only increments
    a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q == BLK_ARMED && tick && !wr_en) |=> (count == $past(count) + 1'b1));
    // R8: overflow lands on zero
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (count == '0));

endmodule

// File: rtl/timer8_events.sv
module timer8_events
    import timer8_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      match,
    input  logic      ovf,
    input  logic      force_wr,
    input  logic      pwm_en,
    input  out_mode_t mode,
    input  logic      clr_ovf_wr,
    input  logic      clr_cmp_wr,
    input  logic      ack_ovf,
    input  logic      ack_cmp,
    input  logic      ie_ovf,
    input  logic      ie_cmp,
    output logic      pin,
    output logic      flag_ovf,
    output logic      flag_cmp,
    output logic      irq_ovf,
    output logic      irq_cmp
);

    logic act;
    logic pin_d;

    always_comb begin
        act   = match || (force_wr && !pwm_en);
        pin_d = pin;
        if (act) begin
            unique case (mode)
                OM_NONE:   pin_d = pin;
                OM_TOGGLE: pin_d = !pin;
                OM_LOW:    pin_d = 1'b0;
                OM_HIGH:   pin_d = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin      <= 1'b0;
            flag_ovf <= 1'b0;
            flag_cmp <= 1'b0;
        end else begin
            pin <= pin_d;
            if (ovf)                          flag_ovf <= 1'b1;
            else if (clr_ovf_wr || ack_ovf)   flag_ovf <= 1'b0;
            if (match)                        flag_cmp <= 1'b1;
            else if (clr_cmp_wr || ack_cmp)   flag_cmp <= 1'b0;
        end
    end

    assign irq_ovf = flag_ovf && ie_ovf;
    assign irq_cmp = flag_cmp && ie_cmp;

    // R12: force in PWM mode leaves the pin alone
    a_r12_pwm_force: assert property (@(posedge clk) disable iff (!rst_n)
        (force_wr && pwm_en && !match) |=> $stable(pin));
    // R4: compare flag rises only from a match
    a_r4_cmp_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_cmp) |-> $past(match));
    // R8: overflow flag rises only from a wrap
    a_r8_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ovf) |-> $past(ovf));

endmodule

// File: rtl/timer8_top.sv
module timer8_top
    import timer8_pkg::*;
#(
    parameter int W      = CNT_W,
    parameter int SEL_W  = CSEL_W,
    parameter int AW     = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic          ack_ovf,
    input  logic          ack_cmp,
    output logic          irq_ovf,
    output logic          irq_cmp,
    output logic          cmp_pin
);

    logic [W-1:0] ctrl_q, cmpa_q, cmpb_q;
    logic [1:0]   ie_q;
    logic [W-1:0] count;
    logic         tick, match, ovf;
    logic         flag_ovf, flag_cmp;
    logic         wr_ctrl, wr_count, wr_cmpa, wr_cmpb, wr_ie, wr_flags, wr_strobe;
    logic         force_wr, prst_wr;
    out_mode_t    mode;

    assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
    assign wr_count  = bus_wr && (bus_addr == A_COUNT);
    assign wr_cmpa   = bus_wr && (bus_addr == A_CMPA);
    assign wr_cmpb   = bus_wr && (bus_addr == A_CMPB);
    assign wr_ie     = bus_wr && (bus_addr == A_IE);
    assign wr_flags  = bus_wr && (bus_addr == A_FLAGS);
    assign wr_strobe = bus_wr && (bus_addr == A_STROBE);
    assign force_wr  = wr_strobe && bus_wdata[SB_FORCE];
    assign prst_wr   = wr_strobe && bus_wdata[SB_PRST];
    assign mode      = out_mode_t'(ctrl_q[CTL_MODE_LO +: 2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmpa_q <= '0;
            cmpb_q <= '0;
            ie_q   <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata;
            if (wr_cmpa) cmpa_q <= bus_wdata;
            if (wr_cmpb) cmpb_q <= bus_wdata;
            if (wr_ie)   ie_q   <= bus_wdata[1:0];
        end
    end

    timer8_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (prst_wr),
        .csel    (ctrl_q[SEL_W-1:0]),
        .tick    (tick)
    );

    timer8_count #(.W(W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .wr_en        (wr_count),
        .wr_data      (bus_wdata),
        .cmpa         (cmpa_q),
        .clr_on_match (ctrl_q[CTL_CLR]),
        .count        (count),
        .match        (match),
        .ovf          (ovf)
    );

    timer8_events u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .match      (match),
        .ovf        (ovf),
        .force_wr   (force_wr),
        .pwm_en     (ctrl_q[CTL_PWM]),
        .mode       (mode),
        .clr_ovf_wr (wr_flags && bus_wdata[FB_OVF]),
        .clr_cmp_wr (wr_flags && bus_wdata[FB_CMP]),
        .ack_ovf    (ack_ovf),
        .ack_cmp    (ack_cmp),
        .ie_ovf     (ie_q[FB_OVF]),
        .ie_cmp     (ie_q[FB_CMP]),
        .pin        (cmp_pin),
        .flag_ovf   (flag_ovf),
        .flag_cmp   (flag_cmp),
        .irq_ovf    (irq_ovf),
        .irq_cmp    (irq_cmp)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_COUNT: bus_rdata = count;
            A_CMPA:  bus_rdata = cmpa_q;
            A_CMPB:  bus_rdata = cmpb_q;
            A_IE:    bus_rdata[1:0] = ie_q;
            A_FLAGS: begin
                bus_rdata[FB_OVF] = flag_ovf;
                bus_rdata[FB_CMP] = flag_cmp;
            end
            default: bus_rdata = '0;
        endcase
    end

    // R3: strobe register never reads back a one
    a_r3_strobe_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STROBE) |-> (bus_rdata == '0));

endmodule

// File: tb/timer8_top_tb.sv
module timer8_top_tb;
    import timer8_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ack_ovf = 1'b0, ack_cmp = 1'b0;
    logic       irq_ovf, irq_cmp, cmp_pin;

    int total = 0;
    int bad   = 0;

    always #10 clk = !clk;

    timer8_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_ovf(ack_ovf),
        .ack_cmp(ack_cmp), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp), .cmp_pin(cmp_pin)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reg after reset", v, 0);
        end
        chk("R1 pin", cmp_pin, 0);
        chk("R1 irq", {irq_ovf, irq_cmp}, 0);
        cyc(5);
        rd(A_COUNT, v);
        chk("R2 stopped at code 0", v, 0);
    endtask

    task automatic t_divide();
        logic [7:0] c0, v;
        wr(A_CTRL, 8'h03);
        wr(A_STROBE, 8'h02);
        rd(A_COUNT, c0);
        cyc(15);
        rd(A_COUNT, v);
        chk("R2 R3 divide by 4, 15 cycles", v, 8'(c0 + 3));
        cyc(1);
        rd(A_COUNT, v);
        chk("R2 R3 divide by 4, 16 cycles", v, 8'(c0 + 4));
        rd(A_STROBE, v);
        chk("R3 strobe reads zero", v, 0);
        wr(A_CTRL, 8'h00);
        wr(A_FLAGS, 8'h03);
    endtask

    task automatic t_match_clear();
        logic [7:0] v;
        wr(A_CTRL, 8'h90);
        wr(A_CMPA, 8'd5);
        wr(A_COUNT, 8'd3);
        wr(A_CTRL, 8'h91);
        cyc(2);
        rd(A_COUNT, v); chk("R4 count reaches compare", v, 5);
        rd(A_FLAGS, v); chk("R4 no flag before match", v, 0);
        cyc(1);
        rd(A_COUNT, v); chk("R5 cleared after match", v, 0);
        rd(A_FLAGS, v); chk("R4 compare flag set", v, 2);
        chk("R6 toggle to high", cmp_pin, 1);
        cyc(6);
        chk("R6 toggle back low", cmp_pin, 0);
        rd(A_COUNT, v); chk("R5 second clear", v, 0);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_block();
        logic [7:0] v;
        wr(A_CTRL, 8'hB0);
        wr(A_FLAGS, 8'h03);
        wr(A_COUNT, 8'd5);
        wr(A_CTRL, 8'hB1);
        cyc(1);
        rd(A_COUNT, v); chk("R7 blocked match increments", v, 6);
        rd(A_FLAGS, v); chk("R7 blocked match no flag", v, 0);
        chk("R7 blocked match no pin action", cmp_pin, 0);
        wr(A_CTRL, 8'h30);
    endtask

    task automatic t_overflow();
        logic [7:0] v;
        wr(A_FLAGS, 8'h03);
        wr(A_IE, 8'h01);
        wr(A_COUNT, 8'hFE);
        wr(A_CTRL, 8'h31);
        cyc(1);
        rd(A_COUNT, v); chk("R8 at top", v, 8'hFF);
        chk("R10 no ovf irq yet", irq_ovf, 0);
        cyc(1);
        rd(A_COUNT, v); chk("R8 wrapped", v, 0);
        rd(A_FLAGS, v); chk("R8 ovf flag", v, 1);
        chk("R10 ovf irq", irq_ovf, 1);
        cyc(6);
        rd(A_COUNT, v); chk("R5 no clear without bit 7", v, 6);
        rd(A_FLAGS, v); chk("R4 cmp flag", v, 3);
        chk("R6 set mode high", cmp_pin, 1);
        chk("R10 cmp irq masked", irq_cmp, 0);
        wr(A_CTRL, 8'h30);
        wr(A_IE, 8'h03);
        chk("R10 cmp irq enabled", irq_cmp, 1);
        @(negedge clk); ack_ovf = 1'b1;
        @(negedge clk); ack_ovf = 1'b0;
        rd(A_FLAGS, v); chk("R9 ack clears ovf only", v, 2);
        chk("R10 ovf irq drops", irq_ovf, 0);
        wr(A_FLAGS, 8'h00);
        rd(A_FLAGS, v); chk("R9 writing zero keeps flag", v, 2);
        wr(A_FLAGS, 8'h02);
        rd(A_FLAGS, v); chk("R9 write one clears", v, 0);
        chk("R10 cmp irq drops", irq_cmp, 0);
        // clear from the top value is not an overflow
        wr(A_CTRL, 8'h80);
        wr(A_CMPA, 8'hFF);
        wr(A_COUNT, 8'hFE);
        wr(A_CTRL, 8'h81);
        cyc(2);
        rd(A_COUNT, v); chk("R8 clear at top", v, 0);
        rd(A_FLAGS, v); chk("R8 no ovf on clear", v, 2);
        wr(A_CTRL, 8'h80);
        wr(A_IE, 8'h00);
    endtask

    task automatic t_force();
        logic [7:0] v;
        wr(A_CMPA, 8'd5);
        wr(A_CTRL, 8'h90);
        wr(A_COUNT, 8'd5);
        wr(A_FLAGS, 8'h03);
        chk("R11 pin before force", cmp_pin, 1);
        wr(A_STROBE, 8'h01);
        chk("R11 force toggles", cmp_pin, 0);
        rd(A_FLAGS, v); chk("R11 force sets no flag", v, 0);
        rd(A_COUNT, v); chk("R11 force keeps count", v, 5);
        wr(A_CTRL, 8'hB0);
        wr(A_STROBE, 8'h01);
        chk("R6 R11 force set", cmp_pin, 1);
        wr(A_CTRL, 8'hA0);
        wr(A_STROBE, 8'h01);
        chk("R6 R11 force clear", cmp_pin, 0);
        wr(A_CTRL, 8'h80);
        wr(A_STROBE, 8'h01);
        chk("R6 mode none holds", cmp_pin, 0);
        wr(A_CTRL, 8'hF0);
        wr(A_STROBE, 8'h01);
        chk("R12 pwm ignores force", cmp_pin, 0);
        rd(A_STROBE, v); chk("R3 strobe reads zero again", v, 0);
    endtask

    task automatic t_cmpb();
        logic [7:0] v;
        wr(A_CTRL, 8'h30);
        wr(A_FLAGS, 8'h03);
        wr(A_CMPB, 8'hA5);
        rd(A_CMPB, v); chk("R13 compare B readback", v, 8'hA5);
        rd(A_COUNT, v); chk("R13 count untouched", v, 5);
        rd(A_FLAGS, v); chk("R13 flags untouched", v, 0);
        chk("R13 pin untouched", cmp_pin, 0);
    endtask

    task automatic run_all();
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_divide();
        t_match_clear();
        t_block();
        t_overflow();
        t_force();
        t_cmpb();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule